// File: doc/BRIEF.md
# Channel-Mask Scan Sequencer

This block runs one scan of a multi-channel converter for each trigger pulse. At the trigger it latches the requested channel mask with the reserved channels removed. It then visits the remaining channels from the lowest index to the highest. For each channel it first writes the channel number and the single-conversion setting, and in a later cycle it strobes start. It then waits in two stages. The first stage waits for end-of-conversion. The second waits until the converter reports that the sampled channel is the one requested. Each stage may poll only a limited number of times, at a fixed spacing. Each result goes into the next free 16-bit slot of a packed buffer.

If either wait runs out, the scan stops. The current slot receives an all-ones marker, the later channels are skipped, and the scan ends flagged invalid. When the converter is owned by this block alone, the block powers it up and waits a settle time before the first conversion, and powers it down when the scan ends. When the converter is shared, or when any channel is reserved, the block keeps it powered and never switches it off.

States: IDLE (wait for trigger), PWR_UP (settle count), PICK (choose the lowest pending channel), CFG (configuration write), START (start strobe), WAIT_EOC (first-stage polling), WAIT_CH (second-stage polling), PWR_DN (switch converter off), FINISH (done pulse).

Transitions:
- IDLE to FINISH on a trigger with an empty mask.
- IDLE to PICK on a trigger in shared mode.
- IDLE to PWR_UP otherwise.
- PWR_UP to PICK after the settle count.
- PICK to CFG when a channel is pending. With none pending, PICK goes to FINISH (shared) or PWR_DN.
- CFG to START, then START to WAIT_EOC.
- WAIT_EOC to WAIT_CH when a poll sees end-of-conversion.
- WAIT_CH to PICK when a poll sees a channel match.
- Either wait state goes to PWR_DN or FINISH on timeout.
- PWR_DN to FINISH, and FINISH to IDLE.

Top module: `chan_scan_seq`

## Requirements
- R1: Enabled channels are converted in strictly ascending index order. The k-th result goes into `res_buf_o[16k +: 16]` with the 10 data bits in bits [9:0] and zeros above. Unwritten slots read zero. `res_cnt_o` gives the number of slots written.
- R2: Each conversion is one cycle with `cv_cfg_we_o` and `cv_single_o` high, followed in the next cycle by one cycle with `cv_start_o` high. `cv_chan_o` carries the same channel in both cycles.
- R3: A result is taken only after a poll has seen `cv_eoc_i` high and a later poll has seen `cv_smp_ch_i` equal to the requested channel. The data is captured at that matching poll.
- R4: In each wait stage, polls fall every POLL_GAP cycles. If the condition is still false at poll number MAX_POLLS, that stage times out.
- R5: On a timeout, the current slot gets 16'hFFFF and is counted, and no later channel is converted. The scan then ends with `invalid_o` high and `valid_o` low.
- R6: In non-shared mode the converter is held powered down (`cv_pwr_dn_o`=1) while idle. For a non-empty scan it is powered up at least SETTLE_CYC cycles before the first configuration write, and powered down again before the done pulse, including after an abort.
- R7: Shared mode is on when `shared_i` is 1 or `rsv_mask_i` is non-zero. In shared mode `cv_pwr_dn_o` stays 0 throughout. A channel set in `rsv_mask_i` is never converted.
- R8: A trigger that arrives while a scan is running is ignored and adds one to `overrun_o`, which saturates at its maximum.
- R9: A trigger with an empty effective mask produces a done pulse with `valid_o`=1 and `res_cnt_o`=0, with no conversion and no power change.
- R10: Every accepted trigger produces exactly one one-cycle `done_o` pulse. During that pulse exactly one of `valid_o` and `invalid_o` is 1.
- R11: After reset the block is idle with `done_o`=0, `cv_start_o`=0, `res_cnt_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Scan trigger pulse |
| scan_mask_i | input | NUM_CH | Requested channels |
| rsv_mask_i | input | NUM_CH | Reserved channels; a non-zero value forces shared mode |
| shared_i | input | 1 | Converter is shared; leave it powered |
| cv_pwr_dn_o | output | 1 | Converter power-down request |
| cv_cfg_we_o | output | 1 | Configuration write strobe |
| cv_chan_o | output | CH_W | Requested channel |
| cv_single_o | output | 1 | Single-conversion mode bit of the configuration |
| cv_start_o | output | 1 | Conversion start strobe |
| cv_eoc_i | input | 1 | End-of-conversion status |
| cv_smp_ch_i | input | CH_W | Channel the converter reports as sampled |
| cv_data_i | input | DATA_W | Conversion data |
| res_buf_o | output | NUM_CH*SLOT_W | Packed result slots |
| res_cnt_o | output | CNT_W | Number of slots written |
| done_o | output | 1 | Scan finished |
| valid_o | output | 1 | Scan complete and valid (with done) |
| invalid_o | output | 1 | Scan aborted on timeout (with done) |
| overrun_o | output | OVR_W | Count of ignored triggers |

## Verification
The bench builds the block with MAX_POLLS=4, POLL_GAP=3 and SETTLE_CYC=5. With these values each wait stage gives up after about twelve cycles, so both the end-of-conversion timeout and the channel-match timeout are short to provoke. A reported channel that lags for a few cycles still resolves well inside the budget. The short settle count keeps power-up checks cheap. Eight channels let one scan fill the whole buffer.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_PICK,
        ST_CFG,
        ST_START,
        ST_WAIT_EOC,
        ST_WAIT_CH,
        ST_PWR_DN,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/chan_pick.sv
// Lowest-set-bit selector over the pending channel set.
module chan_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0]   seen;
    logic [N-1:0] hit;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign hit[i]    = pend_i[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pend_i[i];
    end

    assign found_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/poll_timer.sv
// Produces a poll tick every GAP cycles while running; flags the final allowed poll.
module poll_timer #(
    parameter int GAP = 1,
    parameter int MAX = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o,
    output logic last_o
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int PW = (MAX > 1) ? $clog2(MAX) : 1;

    logic [GW-1:0] gap_q;
    logic [PW-1:0] poll_q;

    assign tick_o = run_i && (gap_q == GW'(GAP - 1));
    assign last_o = tick_o && (poll_q == PW'(MAX - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            poll_q <= '0;
        end else if (clr_i) begin
            gap_q  <= '0;
            poll_q <= '0;
        end else if (run_i) begin
            if (tick_o) begin
                gap_q  <= '0;
                poll_q <= last_o ? poll_q : poll_q + 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R4
    poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clr_i && GAP > 1) |=> !tick_o);
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 10,
    parameter int SLOT_W     = 16,
    parameter int MAX_POLLS  = 20,
    parameter int POLL_GAP   = 1,
    parameter int SETTLE_CYC = 8,
    parameter int OVR_W      = 8,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W     = $clog2(NUM_CH + 1),
    localparam int BUF_W     = NUM_CH * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [NUM_CH-1:0] scan_mask_i,
    input  logic [NUM_CH-1:0] rsv_mask_i,
    input  logic              shared_i,
    output logic              cv_pwr_dn_o,
    output logic              cv_cfg_we_o,
    output logic [CH_W-1:0]   cv_chan_o,
    output logic              cv_single_o,
    output logic              cv_start_o,
    input  logic              cv_eoc_i,
    input  logic [CH_W-1:0]   cv_smp_ch_i,
    input  logic [DATA_W-1:0] cv_data_i,
    output logic [BUF_W-1:0]  res_buf_o,
    output logic [CNT_W-1:0]  res_cnt_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              invalid_o,
    output logic [OVR_W-1:0]  overrun_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    seq_state_e state_q, state_d;

    logic [NUM_CH-1:0] pend_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              abort_q;
    logic              shared_q;
    logic [SW-1:0]     settle_q;
    logic [BUF_W-1:0]  buf_q;
    logic              pwr_dn_q;
    logic [OVR_W-1:0]  ovr_q;

    logic [NUM_CH-1:0] eff_mask;
    logic              shared_now;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic              waiting;
    logic              poll_tick;
    logic              poll_last;
    logic              ch_match;
    seq_state_e        end_state;

    assign eff_mask   = scan_mask_i & ~rsv_mask_i;
    assign shared_now = shared_i | (|rsv_mask_i);
    assign waiting    = (state_q == ST_WAIT_EOC) || (state_q == ST_WAIT_CH);
    assign ch_match   = (cv_smp_ch_i == cur_ch_q);
    assign end_state  = shared_q ? ST_FINISH : ST_PWR_DN;

    chan_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
        .pend_i  (pend_q),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    poll_timer #(.GAP(POLL_GAP), .MAX(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_d != state_q),
        .run_i  (waiting),
        .tick_o (poll_tick),
        .last_o (poll_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_i) begin
                    if (eff_mask == '0)  state_d = ST_FINISH;
                    else if (shared_now) state_d = ST_PICK;
                    else                 state_d = ST_PWR_UP;
                end
            end
            ST_PWR_UP:   if (settle_q == SW'(SETTLE_CYC - 1)) state_d = ST_PICK;
            ST_PICK:     state_d = pick_found ? ST_CFG : end_state;
            ST_CFG:      state_d = ST_START;
            ST_START:    state_d = ST_WAIT_EOC;
            ST_WAIT_EOC: begin
                if (poll_tick && cv_eoc_i) state_d = ST_WAIT_CH;
                else if (poll_last)        state_d = end_state;
            end
            ST_WAIT_CH: begin
                if (poll_tick && ch_match) state_d = ST_PICK;
                else if (poll_last)        state_d = end_state;
            end
            ST_PWR_DN:   state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath and registered state behind the outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            cur_ch_q <= '0;
            cnt_q    <= '0;
            abort_q  <= 1'b0;
            shared_q <= 1'b0;
            settle_q <= '0;
            buf_q    <= '0;
            pwr_dn_q <= 1'b1;
            ovr_q    <= '0;
        end else begin
            if (state_q != ST_IDLE && trig_i && ovr_q != {OVR_W{1'b1}})
                ovr_q <= ovr_q + 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    pwr_dn_q <= !shared_now && !(trig_i && eff_mask != '0);
                    if (trig_i) begin
                        pend_q   <= eff_mask;
                        buf_q    <= '0;
                        cnt_q    <= '0;
                        abort_q  <= 1'b0;
                        shared_q <= shared_now;
                        settle_q <= '0;
                    end
                end
                ST_PWR_UP: settle_q <= settle_q + 1'b1;
                ST_PICK:   if (pick_found) cur_ch_q <= pick_idx;
                ST_WAIT_EOC: begin
                    if (poll_last && !cv_eoc_i) begin
                        buf_q[cnt_q[CH_W-1:0]*SLOT_W +: SLOT_W] <= {SLOT_W{1'b1}};
                        cnt_q   <= cnt_q + 1'b1;
                        abort_q <= 1'b1;
                    end
                end
                ST_WAIT_CH: begin
                    if (poll_tick && ch_match) begin
                        buf_q[cnt_q[CH_W-1:0]*SLOT_W +: SLOT_W] <=
                            {{(SLOT_W - DATA_W){1'b0}}, cv_data_i};
                        pend_q[cur_ch_q] <= 1'b0;
                        cnt_q <= cnt_q + 1'b1;
                    end else if (poll_last) begin
                        buf_q[cnt_q[CH_W-1:0]*SLOT_W +: SLOT_W] <= {SLOT_W{1'b1}};
                        cnt_q   <= cnt_q + 1'b1;
                        abort_q <= 1'b1;
                    end
                end
                ST_PWR_DN: pwr_dn_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign cv_pwr_dn_o = pwr_dn_q;
    assign cv_cfg_we_o = (state_q == ST_CFG);
    assign cv_start_o  = (state_q == ST_START);
    assign cv_single_o = (state_q == ST_CFG) || (state_q == ST_START);
    assign cv_chan_o   = cur_ch_q;
    assign res_buf_o   = buf_q;
    assign res_cnt_o   = cnt_q;
    assign done_o      = (state_q == ST_FINISH);
    assign valid_o     = (state_q == ST_FINISH) && !abort_q;
    assign invalid_o   = (state_q == ST_FINISH) && abort_q;
    assign overrun_o   = ovr_q;

    // R2
    cfg_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start_o |-> ($past(cv_cfg_we_o) && $stable(cv_chan_o)));
    // R6
    start_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start_o |-> !cv_pwr_dn_o);
    // R7
    shared_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && shared_q) |-> !cv_pwr_dn_o);
    // R10
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valid_o != invalid_o));
    // R4
    poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_EOC && poll_last && !cv_eoc_i)
            |=> (state_q == ST_PWR_DN || state_q == ST_FINISH));
endmodule

// File: tb/sim_chan_scan_seq.sv
module sim_chan_scan_seq;
    localparam int NCH    = 8;
    localparam int SETTLE = 5;
    localparam int BW     = NCH * 16;
    localparam int EOC_LAT = 4;
    localparam int LAG    = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           trig = 1'b0;
    logic [NCH-1:0] mask = '0;
    logic [NCH-1:0] rsv = '0;
    logic           shared = 1'b0;
    logic           pwr_dn, cfg_we, single, start;
    logic [2:0]     chan;
    logic           eoc;
    logic [2:0]     smp;
    logic [9:0]     data;
    logic [BW-1:0]  rbuf;
    logic [3:0]     rcnt;
    logic           done, valid, invalid;
    logic [7:0]     ovr;

    always #10 clk = ~clk;

    chan_scan_seq #(.NUM_CH(NCH), .DATA_W(10), .SLOT_W(16), .MAX_POLLS(4),
                    .POLL_GAP(3), .SETTLE_CYC(SETTLE), .OVR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .scan_mask_i(mask),
        .rsv_mask_i(rsv), .shared_i(shared), .cv_pwr_dn_o(pwr_dn),
        .cv_cfg_we_o(cfg_we), .cv_chan_o(chan), .cv_single_o(single),
        .cv_start_o(start), .cv_eoc_i(eoc), .cv_smp_ch_i(smp), .cv_data_i(data),
        .res_buf_o(rbuf), .res_cnt_o(rcnt), .done_o(done), .valid_o(valid),
        .invalid_o(invalid), .overrun_o(ovr));

    // Converter model: fault kinds 0 none, 1 no end-of-conversion,
    // 2 wrong sampled channel forever, 3 wrong sampled channel for LAG cycles.
    int         f_kind = 0;
    logic [2:0] f_ch = '0;
    int         seed = 0;
    logic       m_active = 1'b0;
    int         m_age = 0;
    logic [2:0] m_ch = '0;

    function automatic logic [9:0] data_of(int ch, int sd);
        return 10'((ch * 97 + sd * 41 + 3) % 1024);
    endfunction

    always @(posedge clk) begin
        if (cfg_we) m_active <= 1'b0;
        else if (start) begin
            m_active <= 1'b1;
            m_age    <= 0;
            m_ch     <= chan;
        end else if (m_active) m_age <= m_age + 1;
    end

    assign eoc  = m_active && !(f_kind == 1 && m_ch == f_ch) && (m_age >= EOC_LAT);
    assign smp  = ((f_kind == 2 && m_ch == f_ch) ||
                   (f_kind == 3 && m_ch == f_ch && m_age < EOC_LAT + LAG)) ? m_ch + 3'd1 : m_ch;
    assign data = data_of(int'(m_ch), seed);

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [BW-1:0] buf_v;
        int            cnt;
        bit            ok;
        bit            shr;
        int            starts;
    } exp_t;
    exp_t sb[$];

    // Monitor state
    int  n_starts = 0;
    int  done_seen = 0;
    int  since = 0;
    bit  pwr_prev = 1'b1;
    bit  first_cfg = 1'b0;
    bit  cur_shared = 1'b0;
    int  last_ch = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!pwr_dn && pwr_prev) since = 0;
            else since++;
            pwr_prev = pwr_dn;
            if (cfg_we && first_cfg) begin
                first_cfg = 1'b0;
                if (!cur_shared)
                    chk(since >= SETTLE, "R6 settle before first config", BW'(since), BW'(SETTLE));
            end
            if (start) begin
                n_starts++;
                chk(!pwr_dn, "R6 powered at start", BW'(pwr_dn), '0);
                chk(!rsv[chan], "R7 reserved channel not converted", BW'(chan), '0);
                chk(int'(chan) > last_ch, "R1 ascending order", BW'(chan), BW'(last_ch + 1));
                chk(single, "R2 single mode with start", BW'(single), BW'(1));
                last_ch = int'(chan);
            end
            if (done) begin
                done_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", BW'(1), '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rbuf == e.buf_v, "R1/R5 result buffer", rbuf, e.buf_v);
                    chk(int'(rcnt) == e.cnt, "R1 slot count", BW'(rcnt), BW'(e.cnt));
                    chk(valid == e.ok && invalid == !e.ok, "R5/R10 valid vs invalid",
                        BW'({valid, invalid}), BW'({e.ok, !e.ok}));
                    chk(pwr_dn == !e.shr, "R6/R7 power state at done", BW'(pwr_dn), BW'(!e.shr));
                    chk(n_starts == e.starts, "R5/R9 conversions issued", BW'(n_starts), BW'(e.starts));
                end
            end
        end
    end

    // Driver: computes the expected scan and pushes it to the scoreboard.
    task automatic run_scan(input logic [7:0] m, input logic [7:0] r, input bit sh,
                            input int fk, input int fc, input int sd, input int extra);
        exp_t e;
        logic [7:0] eff;
        bit stop;
        int k;
        int d0;
        @(negedge clk);
        mask = m; rsv = r; shared = sh; f_kind = fk; f_ch = 3'(fc); seed = sd;
        eff = m & ~r;
        e.buf_v = '0; e.ok = 1'b1; e.shr = sh || (r != 0); k = 0; stop = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (eff[c] && !stop) begin
                if ((fk == 1 || fk == 2) && c == fc) begin
                    e.buf_v[k*16 +: 16] = 16'hFFFF;
                    e.ok = 1'b0;
                    stop = 1'b1;
                end else begin
                    e.buf_v[k*16 +: 16] = {6'b0, data_of(c, sd)};
                end
                k++;
            end
        end
        e.cnt = k; e.starts = k;
        sb.push_back(e);
        n_starts = 0; last_ch = -1; first_cfg = 1'b1; cur_shared = e.shr;
        d0 = done_seen;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int x = 0; x < extra; x++) begin
            repeat (3) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        while (done_seen == d0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] ovr0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(done == 0 && start == 0, "R11 no done or start after reset", BW'({done, start}), '0);
        chk(rcnt == 0 && ovr == 0, "R11 count and overrun cleared", BW'({rcnt, ovr}), '0);
        chk(pwr_dn == 1, "R6 idle powered down", BW'(pwr_dn), BW'(1));

        run_scan(8'hA5, 8'h00, 1'b0, 0, 0, 1, 0);   // R1 sparse mask
        run_scan(8'hFF, 8'h00, 1'b0, 3, 3, 2, 0);   // R3 lagging channel report, full buffer
        run_scan(8'h3C, 8'h00, 1'b0, 1, 4, 3, 0);   // R5 end-of-conversion timeout
        run_scan(8'hFF, 8'h00, 1'b0, 2, 1, 4, 0);   // R4 channel-match timeout
        run_scan(8'hFF, 8'h81, 1'b0, 0, 0, 5, 0);   // R7 reserved channels force shared
        run_scan(8'h12, 8'h00, 1'b1, 1, 4, 6, 0);   // R7 abort in shared mode
        run_scan(8'h00, 8'h00, 1'b0, 0, 0, 7, 0);   // R9 empty mask
        run_scan(8'h0F, 8'h0F, 1'b0, 0, 0, 8, 0);   // R9 mask emptied by reservation
        ovr0 = ovr;
        run_scan(8'hF0, 8'h00, 1'b0, 0, 0, 9, 2);   // R8 triggers during a scan
        chk(ovr == ovr0 + 8'd2, "R8 overrun count", BW'(ovr), BW'(ovr0 + 8'd2));
        repeat (40) @(negedge clk);
        chk(sb.size() == 0 && done == 0, "R8 ignored triggers start no scan", BW'(sb.size()), '0);
        run_scan(8'h01, 8'h00, 1'b0, 0, 0, 10, 0);  // R6 back to non-shared
        chk(pwr_dn == 1, "R6 idle powered down after shared use", BW'(pwr_dn), BW'(1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule